// File: doc/BRIEF.md
# Strobed Input Channel with Full Flag and Interrupt

This block is a single strobed input channel of a parallel I/O controller. A peripheral drives a byte onto `pin_data` and pulses the active-low `pin_stb_n`. The channel captures the byte, raises `full`, and raises `irq` toward the processor if its interrupt enable bit is set. The processor reads the byte on `rd_data` with a low pulse on `rd_n` while `rd_sel` is high. It sets or clears the enable bit with a bit set/clear command on `cmd`/`cmd_we`. It can poll `status`, a byte in which only this channel's three flags are placed.

The strobe, read strobe and data pins are asynchronous. Each passes through a two-flop synchroniser, and edges are found on the synchronised copies. A pin change therefore reaches the outputs at the third rising clock edge after it appears. Address decode is done outside the block and arrives as the level `rd_sel`. `CHAN_B` selects whether the instance is placed as the first (0) or the second (1) channel. That choice moves the enable command bit and the status bit positions.

Top module: `strobed_input_channel`

## Requirements
- R1: A falling edge on `pin_stb_n` captures the byte on `pin_data` into `rd_data`, which then holds until the next capture or reset; the new value shows at the third rising clock edge after the strobe falls.
- R2: `full` goes high together with each capture and goes low when a selected read ends (`rd_n` returning high while `rd_sel` is high).
- R3: `irq` is high exactly when the strobe is back high, `full` is set, the enable bit is set and no selected read is in progress (`rd_sel` high with `rd_n` low); with the enable bit clear, a capture leaves `irq` low.
- R4: The falling edge of a selected read drops `irq` while `full` is still high; `irq` stays low until a later capture.
- R5: A command with `cmd_we` high, bit 7 = 0, bits 3:1 = 4 (channel A) or 2 (channel B) loads bit 0 into the enable bit in the same clock; commands with bit 7 = 1 or another bit number leave the enable bit unchanged.
- R6: `status` shows channel A as full on bit 5, enable on bit 4 and irq on bit 3, and channel B as enable on bit 2, full on bit 1 and irq on bit 0; all other bits read 0.
- R7: A capture while `full` is already set overwrites `rd_data` with the new byte and `full` stays high.
- R8: A low pulse on `rd_n` with `rd_sel` low changes neither `full` nor `irq`.
- R9: Synchronous reset `rst` clears `rd_data`, `full`, `irq` and the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| pin_data | input | WIDTH | Peripheral data byte, asynchronous |
| rd_sel | input | 1 | Decoded select for this channel's data port |
| rd_n | input | 1 | Processor read strobe, active low, asynchronous |
| cmd_we | input | 1 | Command write pulse, one clock |
| cmd | input | 8 | Command byte (bit set/clear format) |
| rd_data | output | WIDTH | Latched input byte |
| full | output | 1 | Input buffer full |
| irq | output | 1 | Interrupt request |
| status | output | 8 | Status byte with this channel's flags |

## Verification
On every cycle the assertions check the following:
- `irq` never stands without `full` and without the enable bit.
- `rd_data` moves only when `full` is high afterwards.
- An enable command lands in the next cycle.
- A clear command drops the enable bit.
- Reset empties the channel.

Some behaviours appear only in the bench scenarios, which drive the pins and compare them every clock against a delayed-sample model:
- The synchroniser latency.
- The interrupt drop on the read's falling edge while `full` is still set.
- Overwrite of an unread byte.
- Reads with the select low having no effect.
- Mode-type commands being ignored.

// File: rtl/strobed_input_channel.sv
module strobed_input_channel #(
  parameter int WIDTH  = 8,
  parameter bit CHAN_B = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_stb_n,
  input  logic [WIDTH-1:0] pin_data,
  input  logic             rd_sel,
  input  logic             rd_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             irq,
  output logic [7:0]       status
);
  localparam logic [2:0] EN_BIT = CHAN_B ? 3'd2 : 3'd4;

  logic             stb_m, stb_s, stb_q;
  logic             rd_m, rd_s, rd_q;
  logic [WIDTH-1:0] dat_m, dat_s;
  logic             en;

  always_ff @(posedge clk) begin
    if (rst) begin
      {stb_m, stb_s, stb_q} <= 3'b111;
      {rd_m, rd_s, rd_q}    <= 3'b111;
      dat_m <= '0;
      dat_s <= '0;
    end else begin
      {stb_m, stb_s, stb_q} <= {pin_stb_n, stb_m, stb_s};
      {rd_m, rd_s, rd_q}    <= {rd_n, rd_m, rd_s};
      dat_m <= pin_data;
      dat_s <= dat_m;
    end
  end

  wire stb_fall  = stb_q & ~stb_s;
  wire rd_done   = rd_sel & ~rd_q & rd_s;
  wire rd_active = rd_sel & ~rd_s;
  wire cmd_hit   = cmd_we & ~cmd[7] & (cmd[3:1] == EN_BIT);
  wire en_nx     = cmd_hit ? cmd[0] : en;
  wire full_nx   = stb_fall | (full & ~rd_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      full    <= 1'b0;
      irq     <= 1'b0;
      en      <= 1'b0;
    end else begin
      if (stb_fall) rd_data <= dat_s;
      full <= full_nx;
      en   <= en_nx;
      irq  <= en_nx & full_nx & stb_s & ~rd_active;
    end
  end

  generate
    if (CHAN_B) begin : g_stat_b
      assign status = {5'b0, en, full, irq};
    end else begin : g_stat_a
      assign status = {2'b0, full, en, irq, 3'b0};
    end
  endgenerate
endmodule

// File: rtl/strobed_input_channel_chk.sv
module strobed_input_channel_chk #(
  parameter int WIDTH  = 8,
  parameter bit CHAN_B = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_we,
  input logic [7:0]       cmd,
  input logic [WIDTH-1:0] rd_data,
  input logic             full,
  input logic             irq,
  input logic [7:0]       status
);
  localparam int          EN_POS = CHAN_B ? 2 : 4;
  localparam logic [2:0]  EN_SEL = CHAN_B ? 3'd2 : 3'd4;

  wire en_bit = status[EN_POS];
  wire set_cmd = cmd_we && !cmd[7] && cmd[3:1] == EN_SEL && cmd[0];
  wire clr_cmd = cmd_we && !cmd[7] && cmd[3:1] == EN_SEL && !cmd[0];

  p_irq_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> full);
  p_irq_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> en_bit);
  p_data_moves_on_capture_r1: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> full);
  p_en_set_r5: assert property (@(posedge clk) disable iff (rst)
    set_cmd |=> en_bit);
  p_en_clear_r5: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> !en_bit && !irq);
  p_reset_r9: assert property (@(posedge clk)
    rst |=> (!full && !irq && !en_bit && rd_data == '0));
endmodule

bind strobed_input_channel strobed_input_channel_chk #(.WIDTH(WIDTH), .CHAN_B(CHAN_B)) u_chk (
  .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd(cmd),
  .rd_data(rd_data), .full(full), .irq(irq), .status(status)
);

// File: tb/strobed_input_channel_tb.sv
module strobed_input_channel_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_stb_n = 1'b1;
  logic [7:0] pin_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic       rd_n = 1'b1;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [7:0] rd_data, status;
  logic       full, irq;

  int checks = 0;
  int fails  = 0;
  bit started = 0;

  always #10 clk = ~clk;

  strobed_input_channel u_dut (
    .clk(clk), .rst(rst), .pin_stb_n(pin_stb_n), .pin_data(pin_data),
    .rd_sel(rd_sel), .rd_n(rd_n), .cmd_we(cmd_we), .cmd(cmd),
    .rd_data(rd_data), .full(full), .irq(irq), .status(status)
  );

  // Reference model: pin samples delayed by history, flags by the requirement rules
  bit       hs[3], hr[3];
  bit [7:0] hd[3];
  bit [7:0] m_data;
  bit       m_full, m_irq, m_en, cap, done, busy;

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_data = 0; m_full = 0; m_irq = 0; m_en = 0;
      hs = '{1, 1, 1}; hr = '{1, 1, 1}; hd = '{0, 0, 0};
    end else begin
      cap  = hs[2] && !hs[1];
      done = rd_sel && !hr[2] && hr[1];
      busy = rd_sel && !hr[1];
      if (cmd_we && !cmd[7] && cmd[3:1] == 3'd4) m_en = cmd[0];
      if (cap) begin m_data = hd[1]; m_full = 1; end
      else if (done) m_full = 0;
      m_irq = m_en && m_full && hs[1] && !busy;
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = pin_stb_n;
      hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = rd_n;
      hd[2] = hd[1]; hd[1] = hd[0]; hd[0] = pin_data;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    chk("R1 rd_data", rd_data, m_data);
    chk("R2 full", {7'b0, full}, {7'b0, m_full});
    chk("R3/R4 irq", {7'b0, irq}, {7'b0, m_irq});
    chk("R6 status", status, {2'b0, m_full, m_en, m_irq, 3'b0});
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [7:0] b);
    pin_data = b; wait_n(2);
    pin_stb_n = 1'b0; wait_n(3);
    pin_stb_n = 1'b1; wait_n(5);
  endtask

  task automatic rd_begin(input logic sel);
    rd_sel = sel; rd_n = 1'b0; wait_n(5);
  endtask

  task automatic rd_end();
    rd_n = 1'b1; wait_n(5); rd_sel = 1'b0; wait_n(1);
  endtask

  task automatic command(input logic [7:0] c);
    cmd = c; cmd_we = 1'b1; wait_n(1);
    cmd_we = 1'b0; wait_n(1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3); rst = 1'b0; wait_n(1);
    chk("R9 reset rd_data", rd_data, 8'h00);
    chk("R9 reset status", status, 8'h00);

    strobe(8'hA5);                                   // enable clear
    chk("R1 capture", rd_data, 8'hA5);
    chk("R3 no irq while disabled", {7'b0, irq}, 8'h00);
    rd_begin(1'b1); rd_end();
    chk("R2 full cleared by read", {7'b0, full}, 8'h00);

    command(8'h09);                                  // enable set
    chk("R5 enable set", status, 8'h10);
    strobe(8'h3C);
    chk("R3 irq raised", status, 8'h38);
    rd_begin(1'b0);
    chk("R8 unselected read keeps irq", {7'b0, irq}, 8'h01);
    rd_end();
    chk("R8 unselected read keeps full", {7'b0, full}, 8'h01);
    rd_begin(1'b1);
    chk("R4 irq dropped, full held", status, 8'h30);
    rd_end();
    chk("R2 full cleared", status, 8'h10);

    strobe(8'h11); strobe(8'hE7);
    chk("R7 overwrite data", rd_data, 8'hE7);
    chk("R7 full stays", {7'b0, full}, 8'h01);

    command(8'h88);                                  // mode word, ignored
    chk("R5 mode word ignored", {7'b0, status[4]}, 8'h01);
    command(8'h04);                                  // other bit number
    chk("R5 other bit ignored", {7'b0, status[4]}, 8'h01);
    command(8'h08);                                  // enable clear
    chk("R5 enable cleared drops irq", status, 8'h20);
    command(8'h09);
    chk("R3 irq back with enable", status, 8'h38);

    rst = 1'b1; wait_n(2); rst = 1'b0; wait_n(1);
    chk("R9 reset mid-run data", rd_data, 8'h00);
    chk("R9 reset mid-run status", status, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule